// File: doc/BRIEF.md
# Retriggerable Capture and One-Shot Timer

The block is a 16-bit up-counter that advances on a count-enable strobe. It has a capture register that an edge on an external input pin loads, and a one-shot pulse generator. The pin passes through a two-flop synchronizer and then a selectable edge detector. A valid edge in any running mode copies the counter into the capture register and raises a one-cycle capture interrupt. In the one-shot modes the same edge also acts as a trigger. It clears the counter and starts a new delay-then-pulse sequence, even when a pulse is already in progress. This holds in the software-trigger mode as well.

Software reaches the block through a small register bus with single-cycle writes and reads registered one cycle after the request. The registers are:

| Address | Register | Access | Content |
|---|---|---|---|
| 0 | run-mode field | read/write | bits [1:0] |
| 1 | edge-select field | read/write | bits [1:0] |
| 2 | end compare | read/write | 16 bits |
| 3 | start compare | read/write | 16 bits |
| 4 | capture | read-only | 16 bits |
| 5 | software trigger | write-only | bit 0 |
| 6 | live counter | read-only | 16 bits |

The sequencer has five named states:

- STOPPED: run mode 00.
- FREE: run mode 01, free counting with capture.
- ARMED: a one-shot mode, idle with the counter at 0.
- DELAY: counting toward the start compare.
- PULSE: output high, counting toward the end compare.

Its transitions are:

- mode-write: to STOPPED, FREE or ARMED according to the new mode, with the counter cleared.
- launch: from ARMED to DELAY on a software trigger, or from any one-shot state to DELAY on a pin edge, with the counter cleared.
- rise: from DELAY to PULSE when the counter equals the start compare.
- finish: from PULSE to ARMED when the counter equals the end compare, with the counter cleared.

Top module: `cap_oneshot_timer`

## Requirements
- R1: After reset the run mode, edge select, both compares, the capture register, the counter, `pulse_o`, `cap_irq` and `bus_rdata` are all 0.
- R2: In FREE state the counter adds one on every cycle with `cnt_en` high, holds otherwise, and wraps from 16'hFFFF to 0. Any write to address 0 clears it.
- R3: With run mode not 00, a valid pin edge loads the counter value into the capture register and pulses `cap_irq` high for one cycle. When the pin changes before clock edge E0, the load and the interrupt take effect at edge E2. In run mode 00, pin edges cause no capture and no interrupt.
- R4: Edge-select encoding (bits [1:0] at address 1): 00 falling, 01 rising, 10 no edge, 11 both edges.
- R5: A write to the edge-select field takes effect only while the run mode is 00. Otherwise the field keeps its value.
- R6: When a capture and a read of address 4 fall on the same clock edge, the capture and the interrupt still happen. That read returns the previous capture value, and the next read returns the new one.
- R7: In a one-shot sequence, `pulse_o` goes high on the edge after the counter equals the start compare. It goes low, and the counter clears and stops, on the edge after the counter equals the end compare.
- R8: Writing 1 to bit 0 of address 5 launches a sequence only in run mode 10 and only from ARMED. During DELAY or PULSE, and in run mode 11, it has no effect.
- R9: In run modes 10 and 11, a valid pin edge clears the counter and enters DELAY from any one-shot state. A pulse in progress therefore drops and is emitted again after the full delay.
- R10: Run-mode encoding (bits [1:0] at address 0): 00 stop, 01 free count, 10 one-shot with software and pin trigger, 11 one-shot with pin trigger only. A read request returns the addressed register on `bus_rdata` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one cycle after `bus_rd` |
| cnt_en | input | 1 | Count pulse, one increment per high cycle |
| trig_pin | input | 1 | External capture and trigger pin |
| pulse_o | output | 1 | One-shot pulse output |
| cap_irq | output | 1 | One-cycle capture interrupt |

## Verification
A pin change driven before clock edge E0 yields the capture and `cap_irq` at edge E2, so the bench samples the interrupt on the third falling edge after driving the pin. A launch at edge T puts the counter at j after edge T+j. `pulse_o` is then expected high for samples j = start+1 through end, and the bench compares every sample in a window against that formula. For the same-cycle read case, the read strobe is timed so that it lands on edge E2 itself. Register reads are sampled one falling edge after the request, and a counter read is only issued while the count strobe is low or the counter is held.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        ST_STOPPED,
        ST_FREE,
        ST_ARMED,
        ST_DELAY,
        ST_PULSE
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_STOP   = 2'b00,
        MD_FREE   = 2'b01,
        MD_OS_SW  = 2'b10,
        MD_OS_EXT = 2'b11
    } run_mode_e;

    typedef enum logic [1:0] {
        EG_FALL = 2'b00,
        EG_RISE = 2'b01,
        EG_NONE = 2'b10,
        EG_BOTH = 2'b11
    } edge_sel_e;

    localparam int unsigned A_MODE  = 0;
    localparam int unsigned A_EDGE  = 1;
    localparam int unsigned A_CMP0  = 2;
    localparam int unsigned A_CMP1  = 3;
    localparam int unsigned A_CAP   = 4;
    localparam int unsigned A_TRIG  = 5;
    localparam int unsigned A_COUNT = 6;

endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge
    import tmr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    input  edge_sel_e sel_i,
    output logic      edge_o
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise, fall;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    assign rise = sync_q[LAST] & ~prev_q;
    assign fall = ~sync_q[LAST] & prev_q;

    always_comb begin
        unique case (sel_i)
            EG_FALL: edge_o = fall;
            EG_RISE: edge_o = rise;
            EG_NONE: edge_o = 1'b0;
            EG_BOTH: edge_o = rise | fall;
            default: edge_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cap_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output run_mode_e         mode_o,
    output run_mode_e         mode_new_o,
    output edge_sel_e         esel_o,
    output logic [CNT_W-1:0]  cmp0_o,
    output logic [CNT_W-1:0]  cmp1_o,
    output logic              mode_wr_o,
    output logic              sw_trig_o,
    output logic [CNT_W-1:0]  rdata_o
);
    localparam int unsigned PAD_W = CNT_W - 2;

    logic             esel_wr, cmp0_wr, cmp1_wr;
    logic [CNT_W-1:0] rd_val;

    assign mode_wr_o  = wr_en && (addr == ADDR_W'(A_MODE));
    assign esel_wr    = wr_en && (addr == ADDR_W'(A_EDGE)) && (mode_o == MD_STOP);
    assign cmp0_wr    = wr_en && (addr == ADDR_W'(A_CMP0));
    assign cmp1_wr    = wr_en && (addr == ADDR_W'(A_CMP1));
    assign sw_trig_o  = wr_en && (addr == ADDR_W'(A_TRIG)) && wdata[0];
    assign mode_new_o = run_mode_e'(wdata[1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o <= MD_STOP;
            esel_o <= EG_FALL;
            cmp0_o <= '0;
            cmp1_o <= '0;
        end else begin
            if (mode_wr_o) mode_o <= mode_new_o;
            if (esel_wr)   esel_o <= edge_sel_e'(wdata[1:0]);
            if (cmp0_wr)   cmp0_o <= wdata;
            if (cmp1_wr)   cmp1_o <= wdata;
        end
    end

    always_comb begin
        rd_val = '0;
        if      (addr == ADDR_W'(A_MODE))  rd_val = {{PAD_W{1'b0}}, mode_o};
        else if (addr == ADDR_W'(A_EDGE))  rd_val = {{PAD_W{1'b0}}, esel_o};
        else if (addr == ADDR_W'(A_CMP0))  rd_val = cmp0_o;
        else if (addr == ADDR_W'(A_CMP1))  rd_val = cmp1_o;
        else if (addr == ADDR_W'(A_CAP))   rd_val = cap_i;
        else if (addr == ADDR_W'(A_COUNT)) rd_val = cnt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_o <= '0;
        else if (rd_en) rdata_o <= rd_val;
    end
endmodule

// File: rtl/tmr_seq.sv
module tmr_seq
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  run_mode_e        mode_i,
    input  run_mode_e        mode_new_i,
    input  logic             mode_wr_i,
    input  logic             sw_trig_i,
    input  logic             edge_i,
    input  logic             cnt_en_i,
    input  logic [CNT_W-1:0] cmp0_i,
    input  logic [CNT_W-1:0] cmp1_i,
    output seq_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             cap_irq_o,
    output logic             pulse_o
);
    seq_state_e state_q, state_d;
    logic       cnt_clr, cnt_step, ext_trig, sw_go, cap_hit;

    assign ext_trig = edge_i && (mode_i == MD_OS_SW || mode_i == MD_OS_EXT);
    assign sw_go    = sw_trig_i && (mode_i == MD_OS_SW) && (state_q == ST_ARMED);
    assign cap_hit  = edge_i && (mode_i != MD_STOP);
    assign cnt_step = cnt_en_i &&
                      (state_q == ST_FREE || state_q == ST_DELAY || state_q == ST_PULSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        if (mode_wr_i) begin
            cnt_clr = 1'b1;
            unique case (mode_new_i)
                MD_STOP: state_d = ST_STOPPED;
                MD_FREE: state_d = ST_FREE;
                default: state_d = ST_ARMED;
            endcase
        end else if (ext_trig || sw_go) begin
            cnt_clr = 1'b1;
            state_d = ST_DELAY;
        end else begin
            unique case (state_q)
                ST_STOPPED, ST_FREE, ST_ARMED: state_d = state_q;
                ST_DELAY: if (cnt_o == cmp1_i) state_d = ST_PULSE;
                ST_PULSE: if (cnt_o == cmp0_i) begin
                    state_d = ST_ARMED;
                    cnt_clr = 1'b1;
                end
                default:  state_d = ST_STOPPED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_o <= '0;
        else if (cnt_clr)  cnt_o <= '0;
        else if (cnt_step) cnt_o <= cnt_o + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_o     <= '0;
            cap_irq_o <= 1'b0;
        end else begin
            cap_irq_o <= cap_hit;
            if (cap_hit) cap_o <= cnt_o;
        end
    end

    always_comb begin
        state_o = state_q;
        pulse_o = (state_q == ST_PULSE);
    end
endmodule

// File: rtl/cap_oneshot_timer.sv
module cap_oneshot_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              cnt_en,
    input  logic              trig_pin,
    output logic              pulse_o,
    output logic              cap_irq
);
    run_mode_e        mode_q, mode_new;
    edge_sel_e        esel_q;
    logic [CNT_W-1:0] cmp0_q, cmp1_q, cnt_q, cap_q;
    logic             mode_wr, sw_trig, pin_edge;
    seq_state_e       seq_state;

    tmr_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (trig_pin),
        .sel_i  (esel_q),
        .edge_o (pin_edge)
    );

    tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .rd_en      (bus_rd),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .cap_i      (cap_q),
        .cnt_i      (cnt_q),
        .mode_o     (mode_q),
        .mode_new_o (mode_new),
        .esel_o     (esel_q),
        .cmp0_o     (cmp0_q),
        .cmp1_o     (cmp1_q),
        .mode_wr_o  (mode_wr),
        .sw_trig_o  (sw_trig),
        .rdata_o    (bus_rdata)
    );

    tmr_seq #(.CNT_W(CNT_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_q),
        .mode_new_i (mode_new),
        .mode_wr_i  (mode_wr),
        .sw_trig_i  (sw_trig),
        .edge_i     (pin_edge),
        .cnt_en_i   (cnt_en),
        .cmp0_i     (cmp0_q),
        .cmp1_i     (cmp1_q),
        .state_o    (seq_state),
        .cnt_o      (cnt_q),
        .cap_o      (cap_q),
        .cap_irq_o  (cap_irq),
        .pulse_o    (pulse_o)
    );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input run_mode_e        mode,
    input edge_sel_e        esel,
    input seq_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cap,
    input logic [CNT_W-1:0] cmp0,
    input logic [CNT_W-1:0] cmp1,
    input logic             cnt_en,
    input logic             mode_wr,
    input logic             pin_edge,
    input logic             cap_irq,
    input logic             pulse
);
    logic os_edge;
    assign os_edge = pin_edge && mode[1];

    a_r2_free_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FREE && cnt_en && !mode_wr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    a_r3_stop_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_STOP) |=> !cap_irq);

    a_r3_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |-> (cap == $past(cnt)));

    a_r5_edge_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_STOP) |=> $stable(esel));

    a_r7_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> ($past(cnt) == $past(cmp1)));

    a_r8_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && !os_edge && !mode_wr && cnt != cmp0) |=> (state == ST_PULSE));

    a_r9_retrig_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (os_edge && !mode_wr) |=> (cnt == '0 && state == ST_DELAY));
endmodule

bind cap_oneshot_timer tmr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .esel     (esel_q),
    .state    (seq_state),
    .cnt      (cnt_q),
    .cap      (cap_q),
    .cmp0     (cmp0_q),
    .cmp1     (cmp1_q),
    .cnt_en   (cnt_en),
    .mode_wr  (mode_wr),
    .pin_edge (pin_edge),
    .cap_irq  (cap_irq),
    .pulse    (pulse_o)
);

// File: tb/cap_oneshot_timer_tb_top.sv
module cap_oneshot_timer_tb_top;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [CNT_W-1:0]  bus_wdata = '0;
    logic [CNT_W-1:0]  bus_rdata;
    logic              cnt_en = 1'b0, trig_pin = 1'b0;
    logic              pulse_o, cap_irq;

    int total = 0, fails = 0, irq_seen = 0, cycles = 0;

    cap_oneshot_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_en(cnt_en), .trig_pin(trig_pin), .pulse_o(pulse_o), .cap_irq(cap_irq)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (cap_irq) irq_seen++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = CNT_W'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [CNT_W-1:0] v);
        bus_rd = 1'b1; bus_addr = ADDR_W'(a);
        @(negedge clk);
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic run_cnt(input int n);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic pin_to(input logic v, output int irqs);
        int s;
        s = irq_seen;
        trig_pin = v;
        repeat (5) @(negedge clk);
        irqs = irq_seen - s;
    endtask

    task automatic t_reset;
        logic [CNT_W-1:0] v;
        check("R1 pulse", pulse_o, 0);
        check("R1 irq", cap_irq, 0);
        check("R1 rdata", bus_rdata, 0);
        rd(0, v); check("R1 mode", v, 0);
        rd(1, v); check("R1 edge", v, 0);
        rd(2, v); check("R1 cmp0", v, 0);
        rd(4, v); check("R1 cap", v, 0);
        rd(6, v); check("R1 count", v, 0);
    endtask

    task automatic t_free_count;
        logic [CNT_W-1:0] v;
        wr(0, 1);
        rd(0, v); check("R10 mode readback", v, 1);
        run_cnt(5);
        rd(6, v); check("R2 count 5", v, 5);
        repeat (3) @(negedge clk);
        rd(6, v); check("R2 hold", v, 5);
        run_cnt(65533);
        rd(6, v); check("R2 wrap", v, 2);
    endtask

    task automatic t_capture;
        logic [CNT_W-1:0] v;
        int n;
        pin_to(1'b1, n); check("R4 falling ignores rise", n, 0);
        trig_pin = 1'b0;
        @(negedge clk); check("R3 irq not yet s1", cap_irq, 0);
        @(negedge clk); check("R3 irq not yet s2", cap_irq, 0);
        @(negedge clk); check("R3 irq at E2", cap_irq, 1);
        @(negedge clk); check("R3 irq one cycle", cap_irq, 0);
        rd(4, v); check("R3 captured", v, 2);
        wr(0, 0);
        pin_to(1'b1, n); check("R3 stop rise", n, 0);
        pin_to(1'b0, n); check("R3 stop fall", n, 0);
        wr(1, 1);
        rd(1, v); check("R4 esel write stopped", v, 1);
        wr(0, 1);
        wr(1, 3);
        rd(1, v); check("R5 esel locked", v, 1);
        run_cnt(7);
        pin_to(1'b1, n); check("R4 rising irq", n, 1);
        rd(4, v); check("R4 rising cap", v, 7);
        pin_to(1'b0, n); check("R4 rising ignores fall", n, 0);
        wr(0, 0); wr(1, 2); wr(0, 1);
        run_cnt(3);
        pin_to(1'b1, n); check("R4 none rise", n, 0);
        pin_to(1'b0, n); check("R4 none fall", n, 0);
        rd(4, v); check("R4 none cap kept", v, 7);
        wr(0, 0); wr(1, 3); wr(0, 1);
        run_cnt(3);
        pin_to(1'b1, n); check("R4 both rise", n, 1);
        rd(4, v); check("R4 both cap1", v, 3);
        run_cnt(2);
        pin_to(1'b0, n); check("R4 both fall", n, 1);
        rd(4, v); check("R4 both cap2", v, 5);
    endtask

    task automatic t_collision;
        logic [CNT_W-1:0] v;
        int n;
        wr(0, 0); wr(1, 1); wr(0, 1);
        run_cnt(9);
        trig_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = ADDR_W'(4);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R6 collided read old", bus_rdata, 5);
        check("R6 irq raised", cap_irq, 1);
        rd(4, v); check("R6 next read new", v, 9);
        pin_to(1'b0, n);
    endtask

    task automatic t_oneshot_sw;
        logic [CNT_W-1:0] v;
        int bad;
        wr(0, 0); wr(3, 3); wr(2, 8); wr(0, 2);
        cnt_en = 1'b1;
        bad = 0;
        wr(5, 1);
        for (int j = 0; j < 12; j++) begin
            if (pulse_o !== (j >= 4 && j <= 8)) bad++;
            @(negedge clk);
        end
        check("R7 pulse window", bad, 0);
        rd(6, v); check("R7 counter cleared and held", v, 0);
        bad = 0;
        wr(5, 1);
        for (int j = 0; j < 12; j++) begin
            if (pulse_o !== (j >= 4 && j <= 8)) bad++;
            if (j == 5) begin bus_wr = 1'b1; bus_addr = ADDR_W'(5); bus_wdata = 1; end
            if (j == 6) bus_wr = 1'b0;
            @(negedge clk);
        end
        check("R8 sw trigger ignored in pulse", bad, 0);
        wr(0, 3);
        rd(0, v); check("R10 mode 3 readback", v, 3);
        bad = 0;
        wr(5, 1);
        for (int j = 0; j < 12; j++) begin
            if (pulse_o !== 1'b0) bad++;
            @(negedge clk);
        end
        check("R8 sw trigger ignored in mode 3", bad, 0);
    endtask

    task automatic t_ext_retrig;
        int bad;
        bad = 0;
        trig_pin = 1'b1;
        repeat (3) @(negedge clk);
        for (int j = 0; j < 20; j++) begin
            if (pulse_o !== ((j >= 4 && j <= 6) || (j >= 11 && j <= 15))) bad++;
            if (j == 1) trig_pin = 1'b0;
            if (j == 4) trig_pin = 1'b1;
            @(negedge clk);
        end
        check("R9 retrigger restarts pulse", bad, 0);
        trig_pin = 1'b0;
        repeat (5) @(negedge clk);
        wr(0, 2);
        bad = 0;
        trig_pin = 1'b1;
        repeat (3) @(negedge clk);
        for (int j = 0; j < 12; j++) begin
            if (pulse_o !== (j >= 4 && j <= 8)) bad++;
            @(negedge clk);
        end
        check("R9 pin trigger in sw mode", bad, 0);
        cnt_en = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                total++; fails++;
                $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_free_count();
        t_capture();
        t_collision();
        t_oneshot_sw();
        t_ext_retrig();
        finish_run();
    end
endmodule